// File: doc/BRIEF.md
# Display controller status and interrupt unit

This unit keeps the seven-bit event status word of a display controller and turns it into a single interrupt request. The timing and pixel-fetch logic around it sends one-cycle event pulses. Each pulse sets its status bit on the next clock edge. Software reads the word. To clear bits, it writes a word back in which each bit to clear is zero and each bit to keep is one.

Not every bit obeys that write. The frame-done bit clears only when the controller is switched on again. The sync-lost and FIFO-underflow bits are held at zero while the controller is switched off. The palette-loaded bit clears by write only in the palette-only load mode, and otherwise when the controller is switched off. The line-match bit can be set to clear on the next frame start instead of on a write. When a new event and a clear of the same bit arrive in one cycle, the event wins.

The interrupt line is the OR of the enabled status bits, plus the two error bits while the controller is on. A separate enable gives the line-match source an inverted sense.

Top module: `dispctl_irq_unit`

## Requirements
- R1: After reset, status_o is 0 and irq_o is 0.
- R2: A pulse on ev_i[b] sets status_o[b] at the next rising clock edge. The bit map is: 0 frame done, 1 vsync, 2 sync lost, 3 AC-bias count reached, 4 line match, 5 FIFO underflow, 6 palette loaded.
- R3: Bits 1 (vsync) and 3 (AC-bias) clear on a status write (st_wr_i=1) that holds 0 in their position. A write that holds 1 there leaves them unchanged.
- R4: Bit 0 (frame done) ignores status writes. It clears at the edge where en_i is sampled 1 after having been sampled 0 at the edge before.
- R5: Bits 2 (sync lost) and 5 (underflow) are forced to 0 at every edge where en_i is 0. Events on them are ignored while en_i is 0, and writes never change them.
- R6: Bit 6 (palette loaded) clears on a write with 0 in bit 6 only while load_mode_i is 2'b01 (palette only). In the other modes (2'b00 palette and frame, 2'b10 frame only) writes do not affect it, and it clears at the edge where en_i falls from 1 to 0.
- R7: With line_sel_i=0, bit 4 (line match) clears on a write with 0 in bit 4. With line_sel_i=1, writes do not affect it, and it clears at an edge where frame_start_i is 1.
- R8: When a set and a clear of the same bit meet in one cycle, the bit ends up 1.
- R9: irq_o is the OR of the following terms:
  - ien_i[0] with bit 1;
  - ien_i[1] with bit 0;
  - ien_i[2] with bit 6;
  - ien_i[4] with bit 4;
  - ien_i[3] with bit 4 being 0, which is the inverted line sense.
- R10: While en_i is 1, bit 2 or bit 5 being set drives irq_o to 1, whatever ien_i holds.
- R11: Bit 3 (AC-bias) never drives irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable level |
| load_mode_i | input | 2 | Load mode: 00 palette and frame, 01 palette only, 10 frame only |
| line_sel_i | input | 1 | 1: line-match bit clears on frame start; 0: it clears on write |
| ien_i | input | 5 | Interrupt enables: vsync, done, palette, inverted line, line |
| frame_start_i | input | 1 | Frame start pulse |
| ev_i | input | 7 | Event pulses, one per status bit |
| st_wr_i | input | 1 | Status write strobe |
| st_wdata_i | input | 7 | Status write-back data (0 clears) |
| status_o | output | 7 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong clear rule leaves a status bit wrong at the very next edge. Because irq_o is derived combinationally from the status word, the same error reaches irq_o in that cycle whenever the bit is enabled. The enable edge register is the only other piece of state. If it is wrong, the frame-done or palette bit survives a switch-on or switch-off that should have cleared it, and this shows one edge after en_i toggles. A long pseudo-random sweep over events, writes, modes and enable toggles is compared every cycle against a bit-by-bit model of the rules. Directed sequences cover each clear path and the case where a set and a clear collide.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
    localparam int NSTAT = 7;
    localparam int NIEN  = 5;

    // status bit positions (decoded by software)
    localparam int SB_DONE  = 0;
    localparam int SB_VSYNC = 1;
    localparam int SB_SLOST = 2;
    localparam int SB_ACB   = 3;
    localparam int SB_LINE  = 4;
    localparam int SB_UFLOW = 5;
    localparam int SB_PAL   = 6;

    // interrupt enable positions
    localparam int IE_VSYNC  = 0;
    localparam int IE_DONE   = 1;
    localparam int IE_PAL    = 2;
    localparam int IE_LINE_N = 3;
    localparam int IE_LINE   = 4;

    typedef enum logic [1:0] {
        LM_BOTH  = 2'b00,
        LM_PAL   = 2'b01,
        LM_FRAME = 2'b10,
        LM_RSVD  = 2'b11
    } load_mode_e;

    typedef logic [NSTAT-1:0] stat_t;
    typedef logic [NIEN-1:0]  ien_t;

    typedef struct packed {
        logic en;
    } edge_st_t;

    typedef struct packed {
        stat_t stat;
    } stat_st_t;
endpackage

// File: rtl/dispctl_en_edge.sv
module dispctl_en_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic rise_o,
    output logic fall_o
);
    import dispctl_pkg::*;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.en = en_i;
        rise_o = en_i & ~s_q.en;
        fall_o = ~en_i & s_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dispctl_clr_plan.sv
module dispctl_clr_plan
    import dispctl_pkg::*;
(
    input  logic  en_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  wr_i,
    input  stat_t wdata_i,
    input  logic [1:0] load_mode_i,
    input  logic  line_sel_i,
    input  logic  frame_start_i,
    input  stat_t ev_i,
    output stat_t set_o,
    output stat_t clr_o
);
    stat_t wclr;
    logic  pal_only;

    assign wclr     = wr_i ? ~wdata_i : '0;
    assign pal_only = (load_mode_e'(load_mode_i) == LM_PAL);

    for (genvar b = 0; b < NSTAT; b++) begin : g_bit
        if (b == SB_DONE) begin : g_done
            assign clr_o[b] = rise_i;
            assign set_o[b] = ev_i[b];
        end else if (b == SB_SLOST || b == SB_UFLOW) begin : g_err
            assign clr_o[b] = ~en_i;
            assign set_o[b] = ev_i[b] & en_i;
        end else if (b == SB_LINE) begin : g_line
            assign clr_o[b] = line_sel_i ? frame_start_i : wclr[b];
            assign set_o[b] = ev_i[b];
        end else if (b == SB_PAL) begin : g_pal
            assign clr_o[b] = pal_only ? wclr[b] : fall_i;
            assign set_o[b] = ev_i[b];
        end else begin : g_wr
            assign clr_o[b] = wclr[b];
            assign set_o[b] = ev_i[b];
        end
    end
endmodule

// File: rtl/dispctl_stat_reg.sv
module dispctl_stat_reg
    import dispctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t set_i,
    input  stat_t clr_i,
    output stat_t stat_o
);
    stat_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // a new event outranks any clear in the same cycle
        s_d.stat = (s_q.stat & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;
endmodule

// File: rtl/dispctl_irq_comb.sv
module dispctl_irq_comb
    import dispctl_pkg::*;
(
    input  stat_t stat_i,
    input  ien_t  ien_i,
    input  logic  en_i,
    output logic  irq_o
);
    logic [NIEN-1:0] term;

    always_comb begin
        term[IE_VSYNC]  = ien_i[IE_VSYNC]  & stat_i[SB_VSYNC];
        term[IE_DONE]   = ien_i[IE_DONE]   & stat_i[SB_DONE];
        term[IE_PAL]    = ien_i[IE_PAL]    & stat_i[SB_PAL];
        term[IE_LINE_N] = ien_i[IE_LINE_N] & ~stat_i[SB_LINE];
        term[IE_LINE]   = ien_i[IE_LINE]   & stat_i[SB_LINE];
        irq_o = (|term) | (en_i & (stat_i[SB_SLOST] | stat_i[SB_UFLOW]));
    end
endmodule

// File: rtl/dispctl_irq_unit.sv
module dispctl_irq_unit
    import dispctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] load_mode_i,
    input  logic       line_sel_i,
    input  logic [4:0] ien_i,
    input  logic       frame_start_i,
    input  logic [6:0] ev_i,
    input  logic       st_wr_i,
    input  logic [6:0] st_wdata_i,
    output logic [6:0] status_o,
    output logic       irq_o
);
    logic  rise, fall;
    stat_t set_v, clr_v, stat_q;

    dispctl_en_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    dispctl_clr_plan u_plan (
        .en_i          (en_i),
        .rise_i        (rise),
        .fall_i        (fall),
        .wr_i          (st_wr_i),
        .wdata_i       (st_wdata_i),
        .load_mode_i   (load_mode_i),
        .line_sel_i    (line_sel_i),
        .frame_start_i (frame_start_i),
        .ev_i          (ev_i),
        .set_o         (set_v),
        .clr_o         (clr_v)
    );

    dispctl_stat_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .stat_o (stat_q)
    );

    dispctl_irq_comb u_irq (
        .stat_i (stat_q),
        .ien_i  (ien_i),
        .en_i   (en_i),
        .irq_o  (irq_o)
    );

    assign status_o = stat_q;
endmodule

// File: rtl/dispctl_irq_chk.sv
module dispctl_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       line_sel_i,
    input logic       frame_start_i,
    input logic [6:0] ev_i,
    input logic [6:0] status_o,
    input logic       irq_o
);
    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !en_i) |=> status_o[0]);

    // R5
    err_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (status_o[2] == 1'b0 && status_o[5] == 1'b0));

    // R8
    vsync_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[1] |=> status_o[1]);

    // R8
    done_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[0] |=> status_o[0]);

    // R7
    line_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sel_i && !frame_start_i && status_o[4]) |=> status_o[4]);

    // R10
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (status_o[2] || status_o[5])) |-> irq_o);
endmodule

bind dispctl_irq_unit dispctl_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .line_sel_i    (line_sel_i),
    .frame_start_i (frame_start_i),
    .ev_i          (ev_i),
    .status_o      (status_o),
    .irq_o         (irq_o)
);

// File: tb/sim_dispctl_irq_unit.sv
module sim_dispctl_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       sel = 1'b0;
    logic [4:0] ien = '0;
    logic       fs = 1'b0;
    logic [6:0] ev = '0;
    logic       wr = 1'b0;
    logic [6:0] wd = '0;
    logic [6:0] status;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [6:0] m = '0;
    logic       en_prev = 1'b0;
    logic [31:0] r = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispctl_irq_unit u0 (
        .clk (clk), .rst_n (rst_n), .en_i (en), .load_mode_i (mode),
        .line_sel_i (sel), .ien_i (ien), .frame_start_i (fs), .ev_i (ev),
        .st_wr_i (wr), .st_wdata_i (wd), .status_o (status), .irq_o (irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic string bit_req(input int b);
        case (b)
            0: return "R4 done";
            1: return "R3 vsync";
            2: return "R5 sync lost";
            3: return "R3 ac-bias";
            4: return "R7 line";
            5: return "R5 underflow";
            default: return "R6 palette";
        endcase
    endfunction

    function automatic logic exp_irq();
        return (ien[0] & m[1]) | (ien[1] & m[0]) | (ien[2] & m[6]) |
               (ien[4] & m[4]) | (ien[3] & ~m[4]) | (en & (m[2] | m[5]));
    endfunction

    // one clock: update the model from the driven inputs, then compare
    task automatic step();
        logic rise, fall;
        @(posedge clk);
        rise = en & ~en_prev;
        fall = ~en & en_prev;
        m[0] = ev[0] ? 1'b1 : (rise ? 1'b0 : m[0]);
        m[1] = ev[1] ? 1'b1 : ((wr & ~wd[1]) ? 1'b0 : m[1]);
        m[3] = ev[3] ? 1'b1 : ((wr & ~wd[3]) ? 1'b0 : m[3]);
        m[2] = en & (ev[2] | m[2]);
        m[5] = en & (ev[5] | m[5]);
        m[4] = ev[4] ? 1'b1 : ((sel ? fs : (wr & ~wd[4])) ? 1'b0 : m[4]);
        m[6] = ev[6] ? 1'b1 :
               (((mode == 2'b01) ? (wr & ~wd[6]) : fall) ? 1'b0 : m[6]);
        en_prev = en;
        #1;
        for (int b = 0; b < 7; b++) check(bit_req(b), {7'd0, status[b]}, {7'd0, m[b]});
        check("R9 irq", {7'd0, irq}, {7'd0, exp_irq()});
        @(negedge clk);
        ev = '0; wr = 1'b0; wd = '0; fs = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", {1'b0, status}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        en = 1'b1; step();
        for (int b = 0; b < 7; b++) begin
            ev = 7'(1 << b); step();
            check("R2 event sets bit", {7'd0, status[b]}, 8'h01);
        end
        check("R2 all set", {1'b0, status}, 8'h7f);

        wr = 1'b1; wd = 7'h7d; step();
        check("R3 vsync cleared, ac-bias kept", {1'b0, status}, 8'h7d);
        wr = 1'b1; wd = 7'h00; step();
        check("R4 done ignores write", {1'b0, status}, 8'h65);

        ev = 7'h02; wr = 1'b1; wd = 7'h00; step();
        check("R8 event beats clear", {7'd0, status[1]}, 8'h01);

        ien = '0; step();
        check("R10 error bits raise irq", {7'd0, irq}, 8'h01);

        en = 1'b0; step();
        check("R5 error bits drop on disable, R6 palette on fall", {1'b0, status}, 8'h03);
        ev = 7'h04; step();
        check("R5 sync lost ignored while off", {7'd0, status[2]}, 8'h00);

        mode = 2'b01; ev = 7'h40; step();
        wr = 1'b1; wd = 7'h00; step();
        check("R6 palette write clear in palette-only", {1'b0, status}, 8'h01);

        sel = 1'b1; ev = 7'h10; step();
        wr = 1'b1; wd = 7'h00; step();
        check("R7 line ignores write when auto", {7'd0, status[4]}, 8'h01);
        fs = 1'b1; step();
        check("R7 line clears on frame start", {7'd0, status[4]}, 8'h00);

        en = 1'b1; step();
        check("R4 done clears on re-enable", {7'd0, status[0]}, 8'h00);

        ev = 7'h08; ien = 5'b10111; step();
        check("R11 ac-bias no irq", {7'd0, irq}, 8'h00);
        ien = 5'b01000; step();
        check("R9 inverted line sense", {7'd0, irq}, 8'h01);
        ien = '0; step();

        // pseudo-random sweep against the bit model
        for (int i = 0; i < 4000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            ev  = r[6:0] & r[13:7] & r[20:14];
            wr  = r[21];
            wd  = r[28:22];
            fs  = r[29] & r[30];
            if (r[3:0] == 4'd0) en = ~en;
            if (r[8:4] == 5'd0) mode = r[10:9];
            if (r[15:11] == 5'd0) sel = r[16];
            if (r[19:17] == 3'd0) ien = r[31:27];
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule